// File: doc/BRIEF.md
# Edge-Selectable Interrupt Controller

This block gathers ten interrupt sources into one 32-bit control and status word and drives a single interrupt request line. Seven sources are internal event pulses from neighbouring logic: watchdog, DAC load, FIFO overflow, FIFO almost full, DMA timeout, DMA done and conversion start. The other three come from digital pins used in a secondary role: an external start pin, a second external event pin and a trigger pin.

Each pin passes through a two-flop synchronizer and then an edge detector. A per-pin polarity bit makes that detector fire on the rising edge or on the falling edge. When a pin's function-enable bit is set, its active edge latches a status bit. The start pin and the trigger pin also emit a one-cycle pulse that begins or arms timed conversions. Status bits latch whether or not the source's interrupt is enabled. Software clears a status bit by writing 1 to it. The request line stays high while any enabled status bit is pending.

Top module: `intc_top`

## Requirements
- R1: After reset, the register reads as all zeros, and irqOut, convStart and convArm are low.
- R2: A high cycle on intPulse[i] sets status bit i (register bit 16+i) on the next clock edge. This happens even when enable bit i (register bit i) is clear. Source order for i = 0..6 is watchdog, DAC load, FIFO overflow, FIFO almost full, DMA timeout, DMA done, conversion start.
- R3: A write with 1 in register bit 16+k clears status bit k. A write with 0 there leaves status bit k unchanged.
- R4: When a source event and a write-1-to-clear of the same bit fall on the same edge, the bit remains set.
- R5: irqOut is high exactly when some status bit k and enable bit k are both set. It stays high until every such bit is cleared or disabled.
- R6: Pin p latches status bit 7+p (register bit 23+p). The pin order is 0 = external start, 1 = external event, 2 = trigger. The active edge is rising when polarity bit 26+p is 1 and falling when it is 0. The status bit sets on the third clock edge after the pin changes ahead of an edge.
- R7: While function-enable bit 29+p is 0, transitions on pin p set no status bit and produce no pulse.
- R8: convStart pulses for one cycle, in the same cycle as the status set, for each active edge on pin 0 while that pin's function is enabled. convArm does the same for pin 2.
- R9: Register bits 9:0 (enables), 28:26 (polarity) and 31:29 (function enables) read back as last written. Bits 25:16 read the status bits. Bits 15:10 always read 0.
- R10: Changing a polarity bit while the pin is steady produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data |
| intPulse | input | 7 | Internal source event pulses |
| pinIn | input | 3 | Asynchronous secondary-function pins |
| irqOut | output | 1 | Combined interrupt request |
| convStart | output | 1 | Conversion start pulse from pin 0 |
| convArm | output | 1 | Conversion trigger pulse from pin 2 |

## Verification
The embedded properties check the following on every cycle:
- A status bit rises only after a set event and falls only after a clear.
- A set always beats a clear on the same edge.
- The request holds across any cycle without a write.
- Conversion pulses appear only while their pin function is enabled.

Only the bench scenarios can show:
- The three-edge pin latency.
- The effect of polarity on which edge counts.
- That disabled pins and polarity flips create nothing.
- The exact register layout on readback.

These are checked against a cycle model running under random and directed stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int INT_SRC = 7;
  localparam int PIN_CNT = 3;
  localparam int SRC_CNT = INT_SRC + PIN_CNT;
  localparam int REG_W   = 32;
  localparam int EN_LSB  = 0;
  localparam int ST_LSB  = 16;
  localparam int POL_LSB = 26;
  localparam int FN_LSB  = 29;
  localparam int PIN_START = 0;
  localparam int PIN_EXT   = 1;
  localparam int PIN_TRIG  = 2;

  typedef struct packed {
    logic [SRC_CNT-1:0] setMask;
    logic [SRC_CNT-1:0] clrMask;
    logic               cfgWe;
    logic [SRC_CNT-1:0] enNext;
    logic [PIN_CNT-1:0] polNext;
    logic [PIN_CNT-1:0] fnNext;
    logic               startPulse;
    logic               armPulse;
  } strobe_t;
endpackage

// File: rtl/intc_edge_unit.sv
module intc_edge_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic polRise,
  output logic edgeHit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= pinIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  always_comb begin
    if (polRise) edgeHit = syncQ[LAST] & ~prevQ;
    else         edgeHit = ~syncQ[LAST] & prevQ;
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [INT_SRC-1:0] intPulse,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic [PIN_CNT-1:0] polCur,
  input  logic [PIN_CNT-1:0] fnCur,
  output strobe_t            stb
);
  logic [PIN_CNT-1:0] pinHit;
  logic [PIN_CNT-1:0] pinEvent;

  generate
    for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      intc_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rstN   (rstN),
        .pinIn  (pinIn[p]),
        .polRise(polCur[p]),
        .edgeHit(pinHit[p])
      );
    end
  endgenerate

  assign pinEvent = pinHit & fnCur;

  always_comb begin
    stb            = '0;
    stb.setMask    = {pinEvent, intPulse};
    stb.cfgWe      = wrEn;
    stb.clrMask    = wrEn ? wrData[ST_LSB +: SRC_CNT] : '0;
    stb.enNext     = wrData[EN_LSB +: SRC_CNT];
    stb.polNext    = wrData[POL_LSB +: PIN_CNT];
    stb.fnNext     = wrData[FN_LSB +: PIN_CNT];
    stb.startPulse = pinEvent[PIN_START];
    stb.armPulse   = pinEvent[PIN_TRIG];
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  output logic [REG_W-1:0]   rdData,
  output logic [PIN_CNT-1:0] polCur,
  output logic [PIN_CNT-1:0] fnCur,
  output logic               irqOut,
  output logic               startOut,
  output logic               armOut
);
  logic [SRC_CNT-1:0] enReg;
  logic [SRC_CNT-1:0] stReg;
  logic [PIN_CNT-1:0] polReg;
  logic [PIN_CNT-1:0] fnReg;
  logic               startQ;
  logic               armQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= '0;
      polReg <= '0;
      fnReg  <= '0;
    end else if (stb.cfgWe) begin
      enReg  <= stb.enNext;
      polReg <= stb.polNext;
      fnReg  <= stb.fnNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stReg <= '0;
    else       stReg <= (stReg & ~stb.clrMask) | stb.setMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      armQ   <= 1'b0;
    end else begin
      startQ <= stb.startPulse;
      armQ   <= stb.armPulse;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[EN_LSB +: SRC_CNT]  = enReg;
    rdData[ST_LSB +: SRC_CNT]  = stReg;
    rdData[POL_LSB +: PIN_CNT] = polReg;
    rdData[FN_LSB +: PIN_CNT]  = fnReg;
  end

  assign irqOut   = |(stReg & enReg);
  assign polCur   = polReg;
  assign fnCur    = fnReg;
  assign startOut = startQ;
  assign armOut   = armQ;

  generate
    for (genvar i = 0; i < SRC_CNT; i++) begin : g_chk
      p_rise_needs_event_r2: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) && $rose(stReg[i]) |-> $past(stb.setMask[i]));
      p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) && $fell(stReg[i]) |-> $past(stb.clrMask[i]));
      p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) && $past(stb.setMask[i]) |-> stReg[i]);
    end
  endgenerate

  p_irq_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(irqOut) && !$past(stb.cfgWe) |-> irqOut);
  p_start_needs_fn_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && startOut |-> $past(fnReg[PIN_START]));
  p_arm_needs_fn_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && armOut |-> $past(fnReg[PIN_TRIG]));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic [INT_SRC-1:0] intPulse,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic               irqOut,
  output logic               convStart,
  output logic               convArm
);
  strobe_t            stb;
  logic [PIN_CNT-1:0] polCur;
  logic [PIN_CNT-1:0] fnCur;

  intc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .intPulse(intPulse),
    .pinIn   (pinIn),
    .polCur  (polCur),
    .fnCur   (fnCur),
    .stb     (stb)
  );

  intc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdData  (rdData),
    .polCur  (polCur),
    .fnCur   (fnCur),
    .irqOut  (irqOut),
    .startOut(convStart),
    .armOut  (convArm)
  );
endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [6:0]  intPulse = '0;
  logic [2:0]  pinIn = '0;
  logic        irqOut, convStart, convArm;

  int errors = 0;
  int checks = 0;

  logic [9:0] mEn = '0, mSt = '0;
  logic [2:0] mPol = '0, mFn = '0, ms1 = '0, ms2 = '0, mPrev = '0;
  logic       mStart = 1'b0, mArm = 1'b0;

  always #10 clk = ~clk;

  intc_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .intPulse(intPulse), .pinIn(pinIn), .irqOut(irqOut),
    .convStart(convStart), .convArm(convArm)
  );

  function automatic logic [31:0] expRead();
    return {mFn, mPol, mSt, 6'b0, mEn};
  endfunction

  task automatic check(input logic ok, input string req, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s): actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(rdData == expRead(), "R9", tag, rdData, expRead());
    check(irqOut == |(mSt & mEn), "R5", tag, {31'b0, irqOut}, {31'b0, |(mSt & mEn)});
    check(convStart == mStart, "R8", tag, {31'b0, convStart}, {31'b0, mStart});
    check(convArm == mArm, "R8", tag, {31'b0, convArm}, {31'b0, mArm});
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic [6:0] ip,
                      input logic [2:0] pin, input string tag);
    logic [2:0] hit;
    logic [2:0] ev;
    logic [9:0] clr;
    wrEn = we; wrData = wd; intPulse = ip; pinIn = pin;
    for (int p = 0; p < 3; p++)
      hit[p] = mPol[p] ? (ms2[p] & ~mPrev[p]) : (~ms2[p] & mPrev[p]);
    ev = hit & mFn;
    clr = we ? wd[25:16] : 10'b0;
    @(posedge clk);
    mSt = (mSt & ~clr) | {ev, ip};
    mStart = ev[0];
    mArm = ev[2];
    if (we) begin
      mEn = wd[9:0]; mPol = wd[28:26]; mFn = wd[31:29];
    end
    mPrev = ms2; ms2 = ms1; ms1 = pin;
    @(negedge clk);
    compareAll(tag);
  endtask

  function automatic logic [31:0] cfgWord(input logic [2:0] fn, input logic [2:0] pol,
                                          input logic [9:0] clr, input logic [9:0] en);
    return {fn, pol, clr, 6'b0, en};
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 reset");

    // R2: latch while disabled
    step(1'b0, '0, 7'b0001000, 3'b0, "R2 disabled latch");
    step(1'b0, '0, 7'b0, 3'b0, "R2 hold");
    check(irqOut == 1'b0, "R2", "no irq while disabled", {31'b0, irqOut}, 32'd0);
    // R5: enabling raises irq
    step(1'b1, cfgWord(3'b0, 3'b0, 10'b0, 10'h008), 7'b0, 3'b0, "R5 enable");
    // R3: writing 0 keeps, 1 clears
    step(1'b1, cfgWord(3'b0, 3'b0, 10'h3F7, 10'h008), 7'b0, 3'b0, "R3 zero keeps");
    step(1'b1, cfgWord(3'b0, 3'b0, 10'h008, 10'h008), 7'b0, 3'b0, "R3 clear");
    // R4: set beats clear
    step(1'b1, cfgWord(3'b0, 3'b0, 10'h001, 10'h001), 7'b0000001, 3'b0, "R4 set wins");
    step(1'b1, cfgWord(3'b0, 3'b0, 10'h001, 10'h000), 7'b0, 3'b0, "R4 cleanup");
    // R6: rising on pin 0, falling on pin 2
    step(1'b1, cfgWord(3'b111, 3'b001, 10'h0, 10'h380), 7'b0, 3'b100, "R6 config");
    for (int k = 0; k < 4; k++) step(1'b0, '0, 7'b0, 3'b100, "R6 settle");
    step(1'b0, '0, 7'b0, 3'b001, "R6 edge");
    step(1'b0, '0, 7'b0, 3'b001, "R6 sync1");
    check(rdData[23] == 1'b0, "R6", "not before third edge", {31'b0, rdData[23]}, 32'd0);
    step(1'b0, '0, 7'b0, 3'b001, "R6 sync2");
    check(rdData[23] == 1'b1, "R6", "third edge", {31'b0, rdData[23]}, 32'd1);
    check(rdData[25] == 1'b1, "R6", "falling on pin 2", {31'b0, rdData[25]}, 32'd1);
    for (int k = 0; k < 3; k++) step(1'b0, '0, 7'b0, 3'b001, "R6 tail");
    step(1'b1, cfgWord(3'b000, 3'b001, 10'h3FF, 10'h380), 7'b0, 3'b001, "R7 disable");
    // R7: toggles ignored with function disabled
    for (int k = 0; k < 12; k++) step(1'b0, '0, 7'b0, 3'(k), "R7 ignored");
    check(rdData[25:23] == 3'b0, "R7", "no pin status", {29'b0, rdData[25:23]}, 32'd0);
    // R10: polarity flip on steady pins
    step(1'b1, cfgWord(3'b111, 3'b000, 10'h0, 10'h380), 7'b0, 3'b111, "R10 cfg");
    for (int k = 0; k < 4; k++) step(1'b0, '0, 7'b0, 3'b111, "R10 steady");
    step(1'b1, cfgWord(3'b111, 3'b111, 10'h0, 10'h380), 7'b0, 3'b111, "R10 flip");
    for (int k = 0; k < 4; k++) step(1'b0, '0, 7'b0, 3'b111, "R10 steady");
    check(rdData[25:23] == 3'b0, "R10", "no event from flip", {29'b0, rdData[25:23]}, 32'd0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic        we;
      logic [31:0] wd;
      logic [6:0]  ip;
      logic [2:0]  pin;
      we  = ($urandom % 8) == 0;
      wd  = $urandom;
      ip  = (($urandom % 4) == 0) ? 7'($urandom) : 7'b0;
      pin = (($urandom % 3) == 0) ? 3'($urandom) : pinIn;
      step(we, wd, ip, pin, "R2 R3 R4 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule